// File: doc/BRIEF.md
# SIMD Element Reverse Unit

This datapath block reorders the elements of a vector operand inside fixed-size containers. It takes one 64-bit doubleword in double mode, or two 64-bit doublewords in quad mode. A 2-bit element-size code selects 8, 16 or 32-bit elements. A 2-bit container code selects 64, 32 or 16-bit containers. Inside every container the element order is mirrored. The containers stay where they are, and each doubleword is handled on its own. Data is treated as raw bits, so only the element width has any effect on the result.

The unit also checks whether the request is legal. It rejects any element that is as large as or larger than its container. In quad mode it also rejects any source or destination register index that is odd. A rejected request raises an undefined flag, holds the write enable low and returns an all-zero result. The result is registered one cycle after an input valid pulse. This latency is the same for every request, whatever the data, so timing reveals nothing about operand values. The destination index travels with the result to the register-file write port.

Top module: `simd_rev_unit`

## Requirements
- R1: Size code 0 selects 8-bit elements, 1 selects 16-bit elements and 2 selects 32-bit elements. Size code 3 is reserved and always produces an undefined result.
- R2: Container code 0 selects 64-bit containers, 1 selects 32-bit containers and 2 selects 16-bit containers. Container code 3 always produces an undefined result.
- R3: A request is undefined when the container code plus the size code, taken as unsigned numbers, is 3 or more.
- R4: In quad mode (quad_i=1), a request is undefined if bit 0 of src_idx_i or bit 0 of dst_idx_i is 1. In double mode the index parity has no effect.
- R5: For a legal request, element i of each container (counting from the least significant end) is placed at position (elements per container - 1 - i) of the same container. Containers keep their order. In quad mode, bits 63:0 and bits 127:64 are each permuted independently.
- R6: out_valid_o is high in the cycle after each cycle in which in_valid_i is high, and is low otherwise. The latency is always one cycle and does not depend on data.
- R7: For an undefined request, undef_o=1, wr_en_o=0 and result_o=0. For a legal request, undef_o=0 and wr_en_o=1. wr_en_o and undef_o are only ever high while out_valid_o is high.
- R8: In double mode, result_o[127:64] is zero no matter what src_i[127:64] holds.
- R9: dst_idx_o carries the dst_idx_i value of the request whose result is on result_o.
- R10: After reset, out_valid_o, wr_en_o and undef_o are low and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| src_i | input | 128 | Source vector (the low doubleword is bits 63:0) |
| size_i | input | 2 | Element-size code |
| cont_i | input | 2 | Container code |
| quad_i | input | 1 | 1 = two doublewords, 0 = one doubleword |
| src_idx_i | input | IDX_W | Source register index |
| dst_idx_i | input | IDX_W | Destination register index |
| out_valid_o | output | 1 | Result valid |
| wr_en_o | output | 1 | Destination write enable |
| undef_o | output | 1 | Undefined request flag |
| dst_idx_o | output | IDX_W | Destination index that goes with the result |
| result_o | output | 128 | Permuted result |

## Verification
The hardest cases to reach are the edges of the legality rule. These are the code pairs whose sum is exactly 3, the reserved codes paired with the smallest other code, and quad requests where only one of the two indices is odd. Double-mode requests with odd indices must still pass. The stimulus sweeps every size and container pair in both modes over a byte-numbered pattern, so each misplaced byte can be identified. It then issues back-to-back random requests that mix legal and illegal codes with no gap between them. This shows that a rejected request never leaks the previous result and that the destination index stays paired with its own result.

// File: rtl/simd_rev_pkg.sv
package simd_rev_pkg;
  localparam int unsigned DW_W     = 64;
  localparam int unsigned NUM_DW   = 2;
  localparam int unsigned VEC_W    = DW_W * NUM_DW;
  localparam int unsigned DW_BYTES = DW_W / 8;
  localparam int unsigned BSEL_W   = $clog2(DW_BYTES);

  typedef enum logic [1:0] {
    ESZ_8   = 2'b00,
    ESZ_16  = 2'b01,
    ESZ_32  = 2'b10,
    ESZ_RSV = 2'b11
  } esz_e;

  typedef enum logic [1:0] {
    CNT_64  = 2'b00,
    CNT_32  = 2'b01,
    CNT_16  = 2'b10,
    CNT_RSV = 2'b11
  } cnt_e;

  typedef struct packed {
    logic              legal;
    logic [BSEL_W-1:0] swap_mask;
  } rev_ctl_t;
endpackage

// File: rtl/rev_decode.sv
module rev_decode
  import simd_rev_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [1:0]       size_i,
  input  logic [1:0]       cont_i,
  input  logic             quad_i,
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  output rev_ctl_t         ctl_o
);
  logic [BSEL_W-1:0] cont_mask;
  logic [BSEL_W-1:0] elem_mask;
  logic [2:0]        code_sum;
  logic              pair_ok;
  logic              quad_ok;

  // byte-offset bits spanned by one container
  always_comb begin
    unique case (cnt_e'(cont_i))
      CNT_64:  cont_mask = 3'b111;
      CNT_32:  cont_mask = 3'b011;
      CNT_16:  cont_mask = 3'b001;
      default: cont_mask = 3'b000;
    endcase
  end

  // byte-offset bits spanned by one element
  always_comb begin
    unique case (esz_e'(size_i))
      ESZ_8:   elem_mask = 3'b000;
      ESZ_16:  elem_mask = 3'b001;
      ESZ_32:  elem_mask = 3'b011;
      default: elem_mask = 3'b111;
    endcase
  end

  assign code_sum = {1'b0, cont_i} + {1'b0, size_i};
  assign pair_ok  = (code_sum < 3'd3);
  assign quad_ok  = !quad_i || !(src_idx_i[0] || dst_idx_i[0]);

  // mirroring elements in a power-of-two container inverts the element-index bits
  assign ctl_o.swap_mask = cont_mask & ~elem_mask;
  assign ctl_o.legal     = pair_ok && quad_ok;
endmodule

// File: rtl/rev_dword_perm.sv
module rev_dword_perm
  import simd_rev_pkg::*;
(
  input  logic [DW_W-1:0]   dw_i,
  input  logic [BSEL_W-1:0] swap_mask_i,
  output logic [DW_W-1:0]   dw_o
);
  logic [7:0] src_byte [DW_BYTES];

  for (genvar b = 0; b < DW_BYTES; b++) begin : g_split
    assign src_byte[b] = dw_i[b*8 +: 8];
  end

  for (genvar j = 0; j < DW_BYTES; j++) begin : g_mux
    logic [BSEL_W-1:0] sel;
    assign sel          = BSEL_W'(j) ^ swap_mask_i;
    assign dw_o[j*8 +: 8] = src_byte[sel];
  end
endmodule

// File: rtl/rev_out_stage.sv
module rev_out_stage #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              legal_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  output logic              out_valid_o,
  output logic              wr_en_o,
  output logic              undef_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic [DATA_W-1:0] result_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      wr_en_o     <= 1'b0;
      undef_o     <= 1'b0;
      dst_idx_o   <= '0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      wr_en_o     <= in_valid_i && legal_i;
      undef_o     <= in_valid_i && !legal_i;
      if (in_valid_i) begin
        dst_idx_o <= dst_idx_i;
        result_o  <= legal_i ? data_i : '0;
      end
    end
  end
endmodule

// File: rtl/simd_rev_unit.sv
module simd_rev_unit
  import simd_rev_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [VEC_W-1:0]   src_i,
  input  logic [1:0]         size_i,
  input  logic [1:0]         cont_i,
  input  logic               quad_i,
  input  logic [IDX_W-1:0]   src_idx_i,
  input  logic [IDX_W-1:0]   dst_idx_i,
  output logic               out_valid_o,
  output logic               wr_en_o,
  output logic               undef_o,
  output logic [IDX_W-1:0]   dst_idx_o,
  output logic [VEC_W-1:0]   result_o
);
  rev_ctl_t         ctl;
  logic [VEC_W-1:0] perm_vec;

  rev_decode #(.IDX_W(IDX_W)) u_decode (
    .size_i    (size_i),
    .cont_i    (cont_i),
    .quad_i    (quad_i),
    .src_idx_i (src_idx_i),
    .dst_idx_i (dst_idx_i),
    .ctl_o     (ctl)
  );

  for (genvar d = 0; d < NUM_DW; d++) begin : g_dw
    logic [DW_W-1:0] dw_perm;
    rev_dword_perm u_perm (
      .dw_i        (src_i[d*DW_W +: DW_W]),
      .swap_mask_i (ctl.swap_mask),
      .dw_o        (dw_perm)
    );
    if (d == 0) begin : g_low
      assign perm_vec[d*DW_W +: DW_W] = dw_perm;
    end else begin : g_high
      // upper doublewords only live in quad mode
      assign perm_vec[d*DW_W +: DW_W] = quad_i ? dw_perm : '0;
    end
  end

  rev_out_stage #(.DATA_W(VEC_W), .IDX_W(IDX_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .legal_i     (ctl.legal),
    .data_i      (perm_vec),
    .dst_idx_i   (dst_idx_i),
    .out_valid_o (out_valid_o),
    .wr_en_o     (wr_en_o),
    .undef_o     (undef_o),
    .dst_idx_o   (dst_idx_o),
    .result_o    (result_o)
  );
endmodule

// File: rtl/simd_rev_chk.sv
module simd_rev_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [127:0]     src_i,
  input logic [1:0]       size_i,
  input logic [1:0]       cont_i,
  input logic             quad_i,
  input logic [IDX_W-1:0] src_idx_i,
  input logic [IDX_W-1:0] dst_idx_i,
  input logic             out_valid_o,
  input logic             wr_en_o,
  input logic             undef_o,
  input logic [IDX_W-1:0] dst_idx_o,
  input logic [127:0]     result_o
);
  logic [2:0] code_sum;
  assign code_sum = {1'b0, cont_i} + {1'b0, size_i};

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R6
  AST_BAD_PAIR_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && code_sum >= 3'd3) |=> (undef_o && !wr_en_o)); // R3
  AST_QUAD_ODD_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && quad_i && (src_idx_i[0] || dst_idx_i[0])) |=> undef_o); // R4
  AST_UNDEF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (result_o == '0 && !wr_en_o)); // R7
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || undef_o) |-> out_valid_o); // R7
  AST_DOUBLE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !quad_i) |=> (result_o[127:64] == '0)); // R8
  AST_DST_CARRIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (dst_idx_o == $past(dst_idx_i))); // R9
endmodule

bind simd_rev_unit simd_rev_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .src_i       (src_i),
  .size_i      (size_i),
  .cont_i      (cont_i),
  .quad_i      (quad_i),
  .src_idx_i   (src_idx_i),
  .dst_idx_i   (dst_idx_i),
  .out_valid_o (out_valid_o),
  .wr_en_o     (wr_en_o),
  .undef_o     (undef_o),
  .dst_idx_o   (dst_idx_o),
  .result_o    (result_o)
);

// File: tb/tb_simd_rev_unit.sv
`timescale 1ns/1ps
module tb_simd_rev_unit;
  localparam int IDX_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic [127:0]     src_i = '0;
  logic [1:0]       size_i = '0;
  logic [1:0]       cont_i = '0;
  logic             quad_i = 1'b0;
  logic [IDX_W-1:0] src_idx_i = '0;
  logic [IDX_W-1:0] dst_idx_i = '0;
  logic             out_valid_o, wr_en_o, undef_o;
  logic [IDX_W-1:0] dst_idx_o;
  logic [127:0]     result_o;

  simd_rev_unit #(.IDX_W(IDX_W)) dut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic             undef;
    logic [127:0]     res;
    logic [IDX_W-1:0] dst;
    string            tag;
    int               cyc;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_rev(logic [127:0] src, logic [1:0] sz, logic [1:0] ct, bit q);
    int es  = 8 << sz;
    int cs  = 64 >> ct;
    int epc = cs / es;
    int ndw = q ? 2 : 1;
    logic [127:0] r = '0;
    for (int d = 0; d < ndw; d++)
      for (int k = 0; k < 64 / es; k++) begin
        int dk = (k / epc) * epc + (epc - 1 - (k % epc));
        for (int b = 0; b < es; b++) r[d*64 + dk*es + b] = src[d*64 + k*es + b];
      end
    return r;
  endfunction

  task automatic issue(logic [127:0] src, logic [1:0] sz, logic [1:0] ct, bit q,
                       logic [IDX_W-1:0] si, logic [IDX_W-1:0] di, string tag);
    exp_t e;
    bit legal;
    @(negedge clk_i);
    in_valid_i = 1'b1; src_i = src; size_i = sz; cont_i = ct; quad_i = q;
    src_idx_i = si; dst_idx_i = di;
    legal = ((32'(sz) + 32'(ct)) < 3) && !(q && (si[0] || di[0]));
    e.undef = !legal;
    e.res   = legal ? ref_rev(src, sz, ct, q) : '0;
    e.dst   = di;
    e.tag   = tag;
    e.cyc   = cyc;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      src_i = {$urandom, $urandom, $urandom, $urandom};
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && mon_en && out_valid_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6", "unexpected valid", 128'(out_valid_o), 128'd0);
      end else begin
        cur = sb.pop_front();
        chk(cur.cyc == cyc - 1, "R6", "latency", 128'(cyc - cur.cyc), 128'd1);
        chk(undef_o == cur.undef, cur.tag, "undef", 128'(undef_o), 128'(cur.undef));
        chk(wr_en_o == !cur.undef, "R7", "wr_en", 128'(wr_en_o), 128'(!cur.undef));
        chk(result_o == cur.res, cur.tag, "result", result_o, cur.res);
        chk(dst_idx_o == cur.dst, "R9", "dst_idx", 128'(dst_idx_o), 128'(cur.dst));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "R6", "watchdog expired", 128'd0, 128'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] pat;
    pat = 128'h0f0e0d0c0b0a09080706050403020100;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(out_valid_o == 1'b0, "R10", "out_valid", 128'(out_valid_o), 128'd0);
    chk(wr_en_o == 1'b0, "R10", "wr_en", 128'(wr_en_o), 128'd0);
    chk(undef_o == 1'b0, "R10", "undef", 128'(undef_o), 128'd0);
    chk(result_o == '0, "R10", "result", result_o, 128'd0);
    mon_en = 1'b1;

    // R1 R2 R5 R8: all legal pairs, both modes, upper half nonzero in double mode
    for (int sz = 0; sz < 3; sz++)
      for (int ct = 0; ct < 3; ct++)
        if (sz + ct < 3) begin
          issue(pat, 2'(sz), 2'(ct), 1'b0, 5'd2, 5'd4, "R1 R2 R5 R8");
          issue(pat, 2'(sz), 2'(ct), 1'b1, 5'd2, 5'd6, "R1 R2 R5");
        end
    idle(2);

    // R3 boundary pairs and reserved codes, R1/R2
    issue(pat, 2'd2, 2'd1, 1'b0, 5'd0, 5'd8, "R3");
    issue(pat, 2'd1, 2'd2, 1'b1, 5'd0, 5'd8, "R3");
    issue(pat, 2'd3, 2'd0, 1'b0, 5'd0, 5'd10, "R1 R3");
    issue(pat, 2'd0, 2'd3, 1'b0, 5'd0, 5'd12, "R2 R3");
    issue(pat, 2'd2, 2'd2, 1'b1, 5'd0, 5'd14, "R3");
    issue(pat, 2'd3, 2'd3, 1'b0, 5'd0, 5'd16, "R3");
    issue(pat, 2'd0, 2'd0, 1'b0, 5'd1, 5'd18, "R5");
    idle(1);

    // R4: one odd index at a time; double mode ignores parity
    issue(pat, 2'd0, 2'd0, 1'b1, 5'd3, 5'd4, "R4");
    issue(pat, 2'd1, 2'd0, 1'b1, 5'd2, 5'd5, "R4");
    issue(pat, 2'd0, 2'd1, 1'b1, 5'd4, 5'd8, "R4 R5");
    issue(pat, 2'd0, 2'd0, 1'b0, 5'd3, 5'd5, "R4 R5");
    idle(3);

    // random back-to-back traffic mixing legal and illegal codes
    for (int n = 0; n < 60; n++) begin
      issue({$urandom, $urandom, $urandom, $urandom}, 2'($urandom), 2'($urandom),
            1'($urandom), 5'($urandom), 5'($urandom), "R3 R4 R5 R8");
      if (($urandom % 4) == 0) idle(1);
    end
    idle(4);

    // R6: nothing pending, no stray valid
    chk(sb.size() == 0, "R6", "pending items", 128'(sb.size()), 128'd0);
    chk(out_valid_o == 1'b0, "R6", "idle valid", 128'(out_valid_o), 128'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule